// File: doc/BRIEF.md
# Status Flag Bit Unit

This unit carries out the single-bit instructions of a small 8-bit processor core. It owns the 8-bit status word and accepts one 16-bit instruction word per clock, qualified by a valid strobe. To read a general-purpose register, it drives a 5-bit read address taken straight from the instruction. The register file must return the byte combinationally in the same cycle.

The unit recognises four instruction forms:

- **Flag set / flag clear** force one status bit, selected by index, to 1 or to 0.
- **T capture** copies one bit of a register into the T flag.
- **T insert** writes the T flag into one bit of a register. The result goes out on a write-back port that is active for one cycle.
- **Conditional skip** tests one register bit against an expected polarity. On a match it sends a one-cycle request to the fetch logic to skip the next instruction.

Every other instruction word is ignored.

Control is a three-state phase register:

- `PH_IDLE`: no output is active.
- `PH_WRITE`: the write-back strobe is asserted.
- `PH_SKIP`: the skip request is asserted.

Each clock edge picks the next phase from the instruction accepted on that edge:

- **IDLE/WRITE/SKIP → WRITE**: an accepted T insert.
- **→ SKIP**: an accepted skip whose test bit matches.
- **→ IDLE**: anything else, including no valid instruction.

Because the phase is rebuilt on every edge, both outputs are single-cycle pulses. Two back-to-back qualifying instructions hold the pulse for two cycles.

Top module: `sbu_top`

## Requirements
- R1: After reset the status word reads 0x00 and neither the write-back strobe nor the skip request is asserted.
- R2: A valid word of the form 100101000sss1000 sets status bit sss to 1 and leaves the other seven bits unchanged. Bit indices 0 to 7 are C, Z, N, V, S, H, T, I, so T is bit 6 and I is bit 7.
- R3: A valid word of the form 100101001sss1000 clears status bit sss to 0 and leaves the other bits unchanged.
- R4: A valid word of the form 1111101ddddd0bbb copies bit bbb of register ddddd into T (status bit 6). It changes no other status bit and produces no write-back.
- R5: A valid word of the form 1111100ddddd0bbb produces a write-back to register ddddd. The written value is the register's value with bit bbb replaced by T, and the status word is left unchanged.
- R6: A valid word of the form 111111xddddd0bbb raises the skip request when bit bbb of register ddddd equals x, and otherwise does not. The word changes neither the status word nor any register.
- R7: A valid word that matches none of the forms above has no effect: no status change, no write-back, no skip. This includes words with bit 3 set in the register forms, and flag words whose low nibble is not 1000.
- R8: While valid is low the status word holds and no write-back or skip is produced.
- R9: Results of an instruction accepted on an edge appear right after that edge. The write-back strobe and the skip request are never asserted together, and each lasts one cycle unless the next instruction also qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| rf_raddr | output | 5 | Register-file read address (instruction bits 8:4) |
| rf_rdata | input | 8 | Register-file read data, combinational |
| wb_en | output | 1 | Register write-back strobe |
| wb_addr | output | 5 | Write-back register index |
| wb_data | output | 8 | Write-back value |
| sreg | output | 8 | Status word |
| skip_req | output | 1 | Skip-next-instruction request to fetch |

## Verification
The flag instructions are first driven through a fixed sequence: set I, set C, clear I. They are then swept over all eight indices, which separates a wrong index decode from a wrong set/clear polarity. The T transfers use a byte with a single bit set, moved to another position and back with T both 1 and 0. This shows that exactly one bit is replaced, that only T changes in the status word, and that T capture preserves the other flags. Skip words are tried in all four combinations of polarity and bit value. Near-miss encodings and instructions with valid low show that nothing else decodes.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

    localparam int INSTR_W = 16;
    localparam int DATA_W  = 8;
    localparam int REG_AW  = 5;
    localparam int BIT_AW  = $clog2(DATA_W);
    localparam int T_POS   = 6;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_FSET,
        OP_FCLR,
        OP_TCAPTURE,
        OP_TINSERT,
        OP_SKIP
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [REG_AW-1:0] reg_idx;
        logic [BIT_AW-1:0] bit_idx;
        logic              skip_pol;
    } dec_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WRITE,
        PH_SKIP
    } phase_e;

endpackage

// File: rtl/sbu_decode.sv
module sbu_decode
    import sbu_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output dec_t               dec
);

    logic is_flag_form;
    logic is_reg_form_low;

    always_comb begin
        is_flag_form    = (word[15:8] == 8'b1001_0100) && (word[3:0] == 4'b1000);
        is_reg_form_low = (word[3] == 1'b0);
    end

    always_comb begin
        dec          = '0;
        dec.op       = OP_NONE;
        dec.reg_idx  = word[8:4];
        dec.skip_pol = word[9];
        dec.bit_idx  = word[2:0];
        if (is_flag_form) begin
            dec.bit_idx = word[6:4];
            dec.op      = word[7] ? OP_FCLR : OP_FSET;
        end else if (is_reg_form_low) begin
            unique case (word[15:9])
                7'b1111101: dec.op = OP_TCAPTURE;
                7'b1111100: dec.op = OP_TINSERT;
                7'b1111110,
                7'b1111111: dec.op = OP_SKIP;
                default:    dec.op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/sbu_bitops.sv
module sbu_bitops
    import sbu_pkg::*;
#(
    parameter int W  = DATA_W,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  operand,
    input  logic [AW-1:0] pos,
    input  logic          t_in,
    output logic          picked,
    output logic [W-1:0]  merged
);

    always_comb picked = operand[pos];

    for (genvar i = 0; i < W; i++) begin : g_lane
        always_comb merged[i] = (pos == AW'(i)) ? t_in : operand[i];
    end

endmodule

// File: rtl/sbu_flags.sv
module sbu_flags
    import sbu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int TP = T_POS,
    localparam int AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  op_e           cmd_op,
    input  logic [AW-1:0] cmd_sel,
    input  logic          t_new,
    output logic [W-1:0]  flags_q
);

    logic [W-1:0] flags_d;

    for (genvar i = 0; i < W; i++) begin : g_slice
        logic hit;
        always_comb begin
            hit        = (cmd_sel == AW'(i));
            flags_d[i] = flags_q[i];
            if (cmd_valid) begin
                if (cmd_op == OP_FSET && hit)
                    flags_d[i] = 1'b1;
                else if (cmd_op == OP_FCLR && hit)
                    flags_d[i] = 1'b0;
                else if (cmd_op == OP_TCAPTURE && i == TP)
                    flags_d[i] = t_new;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    AST_SET_HITS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_FSET) |=> flags_q[$past(cmd_sel)]) else $error("set"); // R2
    AST_CLR_HITS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_FCLR) |=> !flags_q[$past(cmd_sel)]) else $error("clr"); // R3
    AST_CAPTURE_ONLY_T: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_TCAPTURE) |=>
            (((flags_q ^ $past(flags_q)) & ~(W'(1) << TP)) == '0)) else $error("cap"); // R4
    AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(flags_q)) else $error("idle"); // R8

endmodule

// File: rtl/sbu_top.sv
module sbu_top
    import sbu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    output logic [REG_AW-1:0]  rf_raddr,
    input  logic [DATA_W-1:0]  rf_rdata,
    output logic               wb_en,
    output logic [REG_AW-1:0]  wb_addr,
    output logic [DATA_W-1:0]  wb_data,
    output logic [DATA_W-1:0]  sreg,
    output logic               skip_req
);

    dec_t              dec;
    logic              bit_sel;
    logic [DATA_W-1:0] ins_val;
    logic              skip_hit;
    phase_e            phase_q, phase_d;
    logic [REG_AW-1:0] wb_addr_q;
    logic [DATA_W-1:0] wb_data_q;

    sbu_decode u_dec (
        .word (instr),
        .dec  (dec)
    );

    always_comb rf_raddr = dec.reg_idx;

    sbu_bitops #(.W(DATA_W)) u_bits (
        .operand (rf_rdata),
        .pos     (dec.bit_idx),
        .t_in    (sreg[T_POS]),
        .picked  (bit_sel),
        .merged  (ins_val)
    );

    sbu_flags #(.W(DATA_W), .TP(T_POS)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (instr_valid),
        .cmd_op    (dec.op),
        .cmd_sel   (dec.bit_idx),
        .t_new     (bit_sel),
        .flags_q   (sreg)
    );

    always_comb skip_hit = (dec.op == OP_SKIP) && (bit_sel == dec.skip_pol);

    // next-phase selection
    always_comb begin
        phase_d = PH_IDLE;
        if (instr_valid) begin
            unique case (dec.op)
                OP_TINSERT: phase_d = PH_WRITE;
                OP_SKIP:    phase_d = skip_hit ? PH_SKIP : PH_IDLE;
                default:    phase_d = PH_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_addr_q <= '0;
            wb_data_q <= '0;
        end else if (instr_valid && dec.op == OP_TINSERT) begin
            wb_addr_q <= dec.reg_idx;
            wb_data_q <= ins_val;
        end
    end

    // outputs from phase
    always_comb begin
        wb_en    = 1'b0;
        skip_req = 1'b0;
        unique case (phase_q)
            PH_WRITE: wb_en    = 1'b1;
            PH_SKIP:  skip_req = 1'b1;
            default:  ;
        endcase
        wb_addr = wb_addr_q;
        wb_data = wb_data_q;
    end

    AST_INSERT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && dec.op == OP_TINSERT) |=> (wb_en && $stable(sreg))) else $error("ins"); // R5
    AST_SKIP_FROM_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> ($past(instr_valid) && !wb_en)) else $error("skip"); // R6
    AST_NONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && dec.op == OP_NONE) |=> (!wb_en && !skip_req && $stable(sreg))) else $error("none"); // R7
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (!wb_en || $past(instr_valid))) else $error("pulse"); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (sreg == '0 && !wb_en && !skip_req)) else $error("rst"); // R1

endmodule

// File: tb/sim_sbu_top.sv
module sim_sbu_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [4:0]  rf_raddr;
    logic [7:0]  rf_rdata;
    logic        wb_en;
    logic [4:0]  wb_addr;
    logic [7:0]  wb_data;
    logic [7:0]  sreg;
    logic        skip_req;

    logic [7:0] rf [32];
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbu_top u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .wb_en(wb_en),
        .wb_addr(wb_addr), .wb_data(wb_data), .sreg(sreg), .skip_req(skip_req)
    );

    assign rf_rdata = rf[rf_raddr];
    always @(posedge clk) if (wb_en) rf[wb_addr] <= wb_data;

    function automatic logic [15:0] f_set(input logic [2:0] s);
        return {9'b100101000, s, 4'b1000};
    endfunction
    function automatic logic [15:0] f_clr(input logic [2:0] s);
        return {9'b100101001, s, 4'b1000};
    endfunction
    function automatic logic [15:0] f_cap(input logic [4:0] d, input logic [2:0] b);
        return {7'b1111101, d, 1'b0, b};
    endfunction
    function automatic logic [15:0] f_ins(input logic [4:0] d, input logic [2:0] b);
        return {7'b1111100, d, 1'b0, b};
    endfunction
    function automatic logic [15:0] f_skip(input logic x, input logic [4:0] d, input logic [2:0] b);
        return {6'b111111, x, d, 1'b0, b};
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // drive one word for one edge; return half a cycle after that edge
    task automatic issue(input logic [15:0] w, input logic v = 1'b1);
        @(negedge clk);
        instr_valid = v;
        instr = w;
        @(negedge clk);
        instr_valid = 1'b0;
        instr = 16'h0000;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 sreg", {8'h0, sreg}, 16'h00);
        chk("R1 wb_en", {15'h0, wb_en}, 16'h0);
        chk("R1 skip", {15'h0, skip_req}, 16'h0);
    endtask

    task automatic t_flags();
        issue(f_set(3'd7));
        issue(f_set(3'd0));
        chk("R2 set I,C", {8'h0, sreg}, 16'h81);
        issue(f_clr(3'd7));
        chk("R3 clr I", {8'h0, sreg}, 16'h01);
        issue(f_clr(3'd0));
        for (int i = 0; i < 8; i++) begin
            issue(f_set(3'(i)));
            chk("R2 sweep set", {8'h0, sreg}, 16'((1 << (i + 1)) - 1));
        end
        for (int i = 0; i < 8; i++) begin
            issue(f_clr(3'(i)));
            chk("R3 sweep clr", {8'h0, sreg}, 16'(8'hFF << (i + 1)) & 16'h00FF);
        end
    endtask

    task automatic t_tbits();
        rf[31] = 8'h10;
        issue(f_cap(5'd31, 3'd4));
        chk("R4 capture T", {8'h0, sreg}, 16'h40);
        chk("R4 no wb", {15'h0, wb_en}, 16'h0);
        issue(f_ins(5'd31, 3'd0));
        chk("R5 wb_en", {15'h0, wb_en}, 16'h1);
        chk("R5 wb_addr", {11'h0, wb_addr}, 16'd31);
        chk("R5 wb_data", {8'h0, wb_data}, 16'h11);
        chk("R5 sreg kept", {8'h0, sreg}, 16'h40);
        idle();
        chk("R9 wb one cycle", {15'h0, wb_en}, 16'h0);
        issue(f_clr(3'd6));
        issue(f_ins(5'd31, 3'd4));
        chk("R5 insert zero", {8'h0, wb_data}, 16'h01);
        chk("R5 sreg zero", {8'h0, sreg}, 16'h00);
        idle();
        issue(f_set(3'd0));
        issue(f_set(3'd1));
        issue(f_set(3'd6));
        rf[5] = 8'h00;
        issue(f_cap(5'd5, 3'd2));
        chk("R4 others kept", {8'h0, sreg}, 16'h03);
        issue(f_clr(3'd0));
        issue(f_clr(3'd1));
    endtask

    task automatic t_skip();
        rf[20] = 8'h08;
        issue(f_skip(1'b1, 5'd20, 3'd3));
        chk("R6 skip-if-set hit", {15'h0, skip_req}, 16'h1);
        chk("R9 no wb with skip", {15'h0, wb_en}, 16'h0);
        idle();
        chk("R9 skip one cycle", {15'h0, skip_req}, 16'h0);
        issue(f_skip(1'b1, 5'd20, 3'd2));
        chk("R6 skip-if-set miss", {15'h0, skip_req}, 16'h0);
        issue(f_skip(1'b0, 5'd20, 3'd2));
        chk("R6 skip-if-clr hit", {15'h0, skip_req}, 16'h1);
        issue(f_skip(1'b0, 5'd20, 3'd3));
        chk("R6 skip-if-clr miss", {15'h0, skip_req}, 16'h0);
        chk("R6 sreg kept", {8'h0, sreg}, 16'h00);
        chk("R6 reg kept", {8'h0, rf[20]}, 16'h08);
    endtask

    task automatic t_ignore();
        rf[7] = 8'hFF;
        issue(16'h0000);
        chk("R7 zero word", {7'h0, wb_en, skip_req, sreg}, 16'h0);
        issue({9'b100101000, 3'd7, 4'b1001});
        chk("R7 bad nibble", {7'h0, wb_en, skip_req, sreg}, 16'h0);
        issue({7'b1111101, 5'd7, 1'b1, 3'd0});
        chk("R7 capture bit3", {7'h0, wb_en, skip_req, sreg}, 16'h0);
        issue({6'b111111, 1'b1, 5'd7, 1'b1, 3'd0});
        chk("R7 skip bit3", {7'h0, wb_en, skip_req, sreg}, 16'h0);
        issue(f_set(3'd5), 1'b0);
        chk("R8 valid low set", {8'h0, sreg}, 16'h00);
        issue(f_skip(1'b1, 5'd7, 3'd0), 1'b0);
        chk("R8 valid low skip", {15'h0, skip_req}, 16'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        idle();
        t_reset();
        t_flags();
        t_tbits();
        t_skip();
        t_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule